// File: doc/BRIEF.md
# Cache Line Refill and Write-Back Sequencer

This block runs the memory side of one data cache line transfer. When a read miss is presented, it can first write back the victim line. The victim is written back only when it is valid and has at least one dirty half. Only the dirty halves go out, and their addresses are built from the physical tag stored with the victim. No address translation is involved. The sequencer then fetches the eight-word line from a word-wide memory port. It starts at the word that missed and wraps around the line.

Each refill beat is written into the data RAM in the cycle it is accepted. The first beat is also handed to the core at once, through a one-cycle critical-word strobe. After the last beat, the block signals that the line is now valid and clean.

Write misses and preload hints never allocate a line. They are accepted and completed in the next cycle with no memory traffic. Tag lookup, the hit path and victim way selection happen elsewhere.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid`, `done`, `line_mark` and `crit_valid` are 0.
- R2: On a read miss (`req_kind` = 2'b00), the refill issues exactly eight read beats. The word indices run `req_word`, `req_word`+1, and so on modulo 8. Each beat's byte address is {`req_line`, word index, 2'b00}.
- R3: In the cycle a read beat is accepted (`mem_valid` and `mem_ready` high, `mem_write` low), `ram_we` is 1, `ram_widx` is that beat's word index and `ram_wdata` equals `mem_rdata`.
- R4: `crit_valid` is 1 only in the cycle the first refill beat is accepted, and `crit_data` then equals `mem_rdata`.
- R5: Victim dirty bit 0 covers words 0–3 and dirty bit 1 covers words 4–7. Write-back sends exactly the words of the dirty halves, in ascending order. Each goes to address {`vic_ptag`, word index, 2'b00}, with `mem_write` = 1 and data `ram_rdata` read at `ram_ridx`.
- R6: Every write-back beat is accepted before the first refill read beat is issued.
- R7: A write miss (`req_kind` 2'b01 or 2'b11) causes no memory beat. `done` is high in the cycle after acceptance, with `line_mark` low.
- R8: A preload hint (`req_kind` = 2'b10) causes no memory beat. `done` is high in the cycle after acceptance, with `line_mark` low.
- R9: A victim whose `vic_valid` is 0 is never written back, whatever its dirty bits.
- R10: After a refill, `done` and `line_mark` are high together for exactly one cycle. That cycle is the one right after the eighth refill beat is accepted.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_write` keep their values into the next cycle.
- R12: `req_ready` is 0 from acceptance until `done` has been seen. Requests presented in that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Sequencer idle, request accepted when both high |
| req_kind | input | 2 | 00 read miss, 01/11 write miss, 10 preload hint |
| req_line | input | 27 | Line address of the missed line |
| req_word | input | 3 | Word offset that missed |
| vic_valid | input | 1 | Victim line holds data |
| vic_dirty | input | 2 | Victim dirty bits, one per half line |
| vic_ptag | input | 27 | Stored physical line address of the victim |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_write | output | 1 | 1 write-back beat, 0 refill read |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid while `mem_ready` on a read |
| ram_ridx | output | 3 | Victim word index read from the data RAM |
| ram_rdata | input | 32 | Data RAM word at `ram_ridx`, same cycle |
| ram_we | output | 1 | Data RAM word write |
| ram_widx | output | 3 | Data RAM word index written |
| ram_wdata | output | 32 | Data RAM write data |
| crit_valid | output | 1 | Critical word delivered this cycle |
| crit_data | output | 32 | Critical word |
| line_mark | output | 1 | Mark line valid and clear both dirty bits |
| done | output | 1 | Request finished |

## Verification
Beat results are due in the same cycle as the accepted handshake: address, write flag, RAM write and critical-word strobe are combinational from state and `mem_ready`. The bench therefore sets `mem_ready` on the falling edge and samples a moment later in the same low phase. `done` is due in the low phase after the edge that accepts the request (write miss, preload) or the last refill beat. The bench records the cycle of each accepted beat and checks that `done` follows it by exactly one. For R11, the address held under backpressure is compared against the value captured one low phase earlier.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
   typedef enum logic [1:0] {
      K_READ    = 2'b00,
      K_WRITE   = 2'b01,
      K_PRELOAD = 2'b10,
      K_WRALT   = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      S_IDLE = 2'b00,
      S_WB   = 2'b01,
      S_FILL = 2'b10,
      S_FIN  = 2'b11
   } seq_state_e;
endpackage

// File: rtl/lfs_wb_mask.sv
module lfs_wb_mask #(
   parameter int WORDS      = 8,
   parameter int DIRTY_BITS = 2
) (
   input  logic                  en,
   input  logic [DIRTY_BITS-1:0] dirty,
   output logic [WORDS-1:0]      mask
);
   localparam int SEG = WORDS / DIRTY_BITS;

   generate
      if (DIRTY_BITS == 1) begin : g_whole
         assign mask = {WORDS{en & dirty[0]}};
      end else begin : g_seg
         for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign mask[w] = en & dirty[w / SEG];
         end
      end
   endgenerate
endmodule

// File: rtl/lfs_first_set.sv
module lfs_first_set #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/lfs_fsm.sv
module lfs_fsm
   import lfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_fire,
   input  logic       is_read,
   input  logic       wb_needed,
   input  logic       beat_fire,
   input  logic       wb_last,
   input  logic       fill_last,
   output seq_state_e state
);
   seq_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE: if (req_fire) nxt = !is_read ? S_FIN : (wb_needed ? S_WB : S_FILL);
         S_WB:   if (beat_fire && wb_last) nxt = S_FILL;
         S_FILL: if (beat_fire && fill_last) nxt = S_FIN;
         S_FIN:  nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
   import lfs_pkg::*;
#(
   parameter int WORDS      = 8,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int DIRTY_BITS = 2,
   localparam int OFF_W     = $clog2(WORDS),
   localparam int BYTE_OFF  = $clog2(DATA_W / 8),
   localparam int LINE_W    = ADDR_W - OFF_W - BYTE_OFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [1:0]            req_kind,
   input  logic [LINE_W-1:0]     req_line,
   input  logic [OFF_W-1:0]      req_word,
   input  logic                  vic_valid,
   input  logic [DIRTY_BITS-1:0] vic_dirty,
   input  logic [LINE_W-1:0]     vic_ptag,
   output logic                  mem_valid,
   input  logic                  mem_ready,
   output logic                  mem_write,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic [OFF_W-1:0]      ram_ridx,
   input  logic [DATA_W-1:0]     ram_rdata,
   output logic                  ram_we,
   output logic [OFF_W-1:0]      ram_widx,
   output logic [DATA_W-1:0]     ram_wdata,
   output logic                  crit_valid,
   output logic [DATA_W-1:0]     crit_data,
   output logic                  line_mark,
   output logic                  done
);
   initial begin
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $fatal(1, "WORDS must be a power of two");
      assert (DIRTY_BITS >= 1 && WORDS % DIRTY_BITS == 0)
         else $fatal(1, "DIRTY_BITS must divide WORDS");
      assert (DATA_W >= 8 && (DATA_W & (DATA_W - 1)) == 0)
         else $fatal(1, "DATA_W must be a power-of-two byte multiple");
      assert (LINE_W > 0) else $fatal(1, "ADDR_W too small");
   end

   seq_state_e             state;
   logic [LINE_W-1:0]      line_q, ptag_q;
   logic [OFF_W-1:0]       crit_q, cnt_q;
   logic [WORDS-1:0]       wb_mask_q, mask_in, wb_rest;
   logic                   fill_q;
   logic [OFF_W-1:0]       wb_idx, fill_idx;
   logic                   req_fire, is_read, beat_fire;

   assign req_ready = (state == S_IDLE);
   assign req_fire  = req_ready & req_valid;
   assign is_read   = (req_kind == K_READ);
   assign beat_fire = mem_valid & mem_ready;

   lfs_wb_mask #(.WORDS(WORDS), .DIRTY_BITS(DIRTY_BITS)) u_mask (
      .en   (is_read & vic_valid),
      .dirty(vic_dirty),
      .mask (mask_in)
   );

   lfs_first_set #(.N(WORDS), .IW(OFF_W)) u_pick (
      .vec(wb_mask_q),
      .idx(wb_idx)
   );

   assign wb_rest  = wb_mask_q & ~(WORDS'(1) << wb_idx);
   assign fill_idx = crit_q + cnt_q;

   lfs_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_fire (req_fire),
      .is_read  (is_read),
      .wb_needed(|mask_in),
      .beat_fire(beat_fire),
      .wb_last  (wb_rest == '0),
      .fill_last(cnt_q == OFF_W'(WORDS - 1)),
      .state    (state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q    <= '0;
         ptag_q    <= '0;
         crit_q    <= '0;
         cnt_q     <= '0;
         wb_mask_q <= '0;
         fill_q    <= 1'b0;
      end else if (req_fire) begin
         line_q    <= req_line;
         ptag_q    <= vic_ptag;
         crit_q    <= req_word;
         cnt_q     <= '0;
         wb_mask_q <= mask_in;
         fill_q    <= is_read;
      end else if (beat_fire) begin
         if (state == S_WB)   wb_mask_q <= wb_rest;
         if (state == S_FILL) cnt_q     <= cnt_q + 1'b1;
      end
   end

   assign mem_valid  = (state == S_WB) || (state == S_FILL);
   assign mem_write  = (state == S_WB);
   assign mem_addr   = mem_write ? {ptag_q, wb_idx, {BYTE_OFF{1'b0}}}
                                 : {line_q, fill_idx, {BYTE_OFF{1'b0}}};
   assign ram_ridx   = wb_idx;
   assign mem_wdata  = ram_rdata;
   assign ram_we     = (state == S_FILL) & mem_ready;
   assign ram_widx   = fill_idx;
   assign ram_wdata  = mem_rdata;
   assign crit_valid = ram_we & (cnt_q == '0);
   assign crit_data  = mem_rdata;
   assign done       = (state == S_FIN);
   assign line_mark  = (state == S_FIN) & fill_q;
endmodule

// File: rtl/lfs_chk.sv
module lfs_chk #(
   parameter int WORDS  = 8,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              ram_we,
   input logic              crit_valid,
   input logic              line_mark,
   input logic              done
);
   localparam int CW = $clog2(WORDS) + 1;
   logic [CW-1:0] fill_cnt;
   logic          seen_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_cnt  <= '0;
         seen_read <= 1'b0;
      end else if (done) begin
         fill_cnt  <= '0;
         seen_read <= 1'b0;
      end else if (mem_valid && mem_ready && !mem_write) begin
         fill_cnt  <= fill_cnt + 1'b1;
         seen_read <= 1'b1;
      end
   end

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));
   // R6
   wb_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_write |-> !seen_read);
   // R3
   ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> mem_valid && mem_ready && !mem_write);
   // R4
   crit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crit_valid |-> fill_cnt == '0);
   // R4
   crit_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we && fill_cnt == '0 |-> crit_valid);
   // R10
   fill_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_mark |-> fill_cnt == CW'(WORDS));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R12
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);
endmodule

bind line_fill_seq lfs_chk #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_write (mem_write),
   .mem_addr  (mem_addr),
   .ram_we    (ram_we),
   .crit_valid(crit_valid),
   .line_mark (line_mark),
   .done      (done)
);

// File: tb/tb_line_fill_seq.sv
module tb_line_fill_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [1:0]  req_kind = '0;
   logic [26:0] req_line = '0, vic_ptag = '0;
   logic [2:0]  req_word = '0;
   logic        vic_valid = 1'b0;
   logic [1:0]  vic_dirty = '0;
   logic        mem_valid, mem_ready = 1'b0, mem_write;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, ram_rdata, ram_wdata, crit_data;
   logic [2:0]  ram_ridx, ram_widx;
   logic        ram_we, crit_valid, line_mark, done;
   logic [31:0] ram_m [8];

   int vectors = 0;
   int fails   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] dfn(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
   endfunction

   assign mem_rdata = dfn(mem_addr);
   assign ram_rdata = ram_m[ram_ridx];

   line_fill_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_line(req_line), .req_word(req_word),
      .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_ptag(vic_ptag),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ram_ridx(ram_ridx), .ram_rdata(ram_rdata), .ram_we(ram_we),
      .ram_widx(ram_widx), .ram_wdata(ram_wdata), .crit_valid(crit_valid),
      .crit_data(crit_data), .line_mark(line_mark), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_txn(input logic [1:0] kind, input logic [26:0] line, input logic [2:0] word,
                          input logic vv, input logic [1:0] dirty, input logic [26:0] ptag,
                          input bit noise);
      logic        exp_w [16];
      logic [2:0]  exp_i [16];
      logic [31:0] exp_a [16];
      int n_exp = 0, n_wb = 0, beats = 0, last_c = -10;
      bit got_done = 0, hold_pend = 0;
      logic [31:0] hold_addr = '0;
      logic hold_wr = 1'b0;
      for (int i = 0; i < 8; i++) ram_m[i] = $urandom;
      if (kind == 2'b00) begin
         for (int i = 0; i < 8; i++)
            if (vv && dirty[i / 4]) begin
               exp_w[n_exp] = 1'b1; exp_i[n_exp] = 3'(i);
               exp_a[n_exp] = {ptag, 3'(i), 2'b00}; n_exp++; n_wb++;
            end
         for (int i = 0; i < 8; i++) begin
            exp_w[n_exp] = 1'b0; exp_i[n_exp] = word + 3'(i);
            exp_a[n_exp] = {line, word + 3'(i), 2'b00}; n_exp++;
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_line = line; req_word = word;
      vic_valid = vv; vic_dirty = dirty; vic_ptag = ptag;
      #1 chk(req_ready == 1'b1, "R12", 32'(req_ready), 32'd1);
      for (int c = 0; c < 300 && !got_done; c++) begin
         @(negedge clk);
         req_valid = noise;
         if (noise) begin req_kind = 2'($urandom); req_line = 27'($urandom); req_word = 3'($urandom); end
         mem_ready = ($urandom % 4) != 0;
         #1;
         if (hold_pend)
            chk(mem_valid && mem_addr == hold_addr && mem_write == hold_wr, "R11", mem_addr, hold_addr);
         hold_pend = mem_valid && !mem_ready; hold_addr = mem_addr; hold_wr = mem_write;
         chk(req_ready == 1'b0, "R12", 32'(req_ready), 32'd0);
         if (done) begin
            got_done = 1;
            req_valid = 1'b0;
            chk(beats == n_exp, "R2", 32'(beats), 32'(n_exp));
            chk(line_mark == (kind == 2'b00), "R10", 32'(line_mark), 32'(kind == 2'b00));
            if (kind == 2'b00) chk(last_c == c - 1, "R10", 32'(c - last_c), 32'd1);
            else if (kind == 2'b10) chk(c == 0, "R8", 32'(c), 32'd0);
            else chk(c == 0, "R7", 32'(c), 32'd0);
         end else if (mem_valid && mem_ready) begin
            if (beats < n_exp) begin
               chk(mem_write == exp_w[beats] && mem_addr == exp_a[beats],
                   exp_w[beats] ? "R5" : (vv ? "R2" : "R9"), mem_addr, exp_a[beats]);
               if (exp_w[beats]) begin
                  chk(mem_wdata == ram_m[exp_i[beats]], "R5", mem_wdata, ram_m[exp_i[beats]]);
               end else begin
                  chk(beats >= n_wb, "R6", 32'(beats), 32'(n_wb));
                  chk(ram_we && ram_widx == exp_i[beats] && ram_wdata == dfn(exp_a[beats]),
                      "R3", ram_wdata, dfn(exp_a[beats]));
                  chk(crit_valid == (beats == n_wb) && (!crit_valid || crit_data == mem_rdata),
                      "R4", 32'(crit_valid), 32'(beats == n_wb));
                  ram_m[exp_i[beats]] = mem_rdata;
               end
            end else begin
               chk(1'b0, kind == 2'b10 ? "R8" : "R7", 32'(beats), 32'(n_exp));
            end
            beats++; last_c = c;
         end else begin
            chk(!ram_we && !crit_valid, "R3", 32'(ram_we), 32'd0);
         end
      end
      if (!got_done) chk(1'b0, "R10 watchdog", 32'(beats), 32'(n_exp));
      req_valid = 1'b0;
      mem_ready = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);
      chk(!mem_valid && !done && !line_mark && !crit_valid, "R1", 32'(mem_valid), 32'd0);
      @(negedge clk) rst_n = 1'b1;
      // directed corners
      run_txn(2'b00, 27'h123_4567, 3'd0, 1'b1, 2'b00, 27'h765_4321, 0);
      run_txn(2'b00, 27'h0AB_CDEF, 3'd5, 1'b1, 2'b11, 27'h1FF_0000, 0);
      run_txn(2'b00, 27'h000_0010, 3'd3, 1'b1, 2'b01, 27'h055_5555, 0);
      run_txn(2'b00, 27'h7FF_FFFF, 3'd7, 1'b1, 2'b10, 27'h2AA_AAAA, 0);
      run_txn(2'b00, 27'h010_2030, 3'd2, 1'b0, 2'b11, 27'h3FF_FFFF, 0); // R9
      run_txn(2'b01, 27'h111_1111, 3'd4, 1'b1, 2'b11, 27'h222_2222, 0); // R7
      run_txn(2'b11, 27'h131_1111, 3'd1, 1'b1, 2'b01, 27'h242_2222, 0); // R7
      run_txn(2'b10, 27'h333_3333, 3'd6, 1'b1, 2'b11, 27'h444_4444, 0); // R8
      run_txn(2'b00, 27'h555_5555, 3'd4, 1'b1, 2'b11, 27'h666_6666, 1); // R12
      for (int n = 0; n < 60; n++)
         run_txn(2'($urandom % 5 == 0 ? $urandom : 0), 27'($urandom), 3'($urandom),
                 1'($urandom), 2'($urandom), 27'($urandom), 1'($urandom % 4 == 0));
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule